// File: doc/BRIEF.md
# ADC Acquisition Sequencer

This block paces a multi-channel ADC acquisition unit. Each request from a conversion clock source becomes a one-cycle conversion pulse to the converters. The number of pulses is limited to a programmed total. Each finished conversion, seen as the falling edge of a shared busy line, becomes one write into a sample FIFO. The block counts stored samples and ends the run when the total is reached.

The block has two modes. In normal mode a software start begins a single run. In frame mode every rising edge on the frame trigger starts a new run of the programmed length, so the block re-arms itself after each frame.

Three faults stop the unit and halt it:
- a frame trigger that arrives in the middle of a frame;
- a conversion request while the converters are still occupied;
- a sample that is ready while the FIFO is full.

Each fault sets a sticky flag in a 16-bit status word. The unit stays halted until its enable is dropped.

Top module: `adc_seq_ctrl`

## Requirements
- R1: During reset the status word reads 0x0001 (idle only), and conv_pulse_o and fifo_wr_o are low.
- R2: In normal mode (frame_mode_i=0) a sw_start_i high in the idle state starts a run. Status bit 2 (active) is 1 and bit 0 (idle) is 0 in the following cycle. In normal mode frame triggers are ignored. In frame mode sw_start_i is ignored.
- R3: While a run is active, a conv_req_i with the converters free and fewer than the effective total pulses issued gives a conv_pulse_o high for exactly the next cycle. Once the total has been issued, further requests give no pulse.
- R4: A falling edge of adc_busy_i during a run with the FIFO not full gives fifo_wr_o high for exactly the next cycle. In that cycle fifo_data_o holds adc_data_i as sampled at the falling edge. No write follows a cycle in which fifo_full_i was high.
- R5: When the last of the programmed number of samples is stored, active clears and idle sets in the same cycle as that write. A programmed total of 0 runs exactly one conversion.
- R6: In frame mode (frame_mode_i=1) each rising edge of frame_trig_i seen in the idle state starts a run of the programmed length. The block re-arms after each completed frame.
- R7: A rising edge of frame_trig_i in frame mode during an active run sets status bit 6 (frame error) and halts. Active is not set, and no further pulses follow.
- R8: A conv_req_i while adc_busy_i is high, or while an issued conversion has not yet been stored, sets status bit 5 (conversion error) and halts.
- R9: A falling edge of adc_busy_i while fifo_full_i is high during a run sets status bit 4 (FIFO overflow), produces no write, and halts.
- R10: While halted, idle and active are both 0. No conversion pulse or FIFO write is produced, and start and trigger inputs have no effect.
- R11: The error flags stay set while enable_i is high. One cycle after enable_i is low, the status word reads 0x0001. Enabling again allows a fresh run.
- R12: Status bits 1, 3 and 15:7 always read 0. Idle and active are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Unit enable; low returns to idle and clears the error flags |
| frame_mode_i | input | 1 | 0: software-started run, 1: frame-triggered runs |
| sw_start_i | input | 1 | Software start, normal mode |
| frame_trig_i | input | 1 | External frame trigger, frame mode |
| conv_total_i | input | CNT_W | Conversions per run (0 means 1) |
| conv_req_i | input | 1 | Request tick from the conversion clock source |
| adc_busy_i | input | 1 | High from the conversion pulse until results are valid |
| adc_data_i | input | DATA_W | Converter result, valid when busy falls |
| fifo_full_i | input | 1 | Sample FIFO full |
| conv_pulse_o | output | 1 | One-cycle conversion start to the converters |
| fifo_wr_o | output | 1 | One-cycle FIFO write strobe |
| fifo_data_o | output | DATA_W | Sample written with fifo_wr_o |
| status_o | output | 16 | Status word: bit 0 idle, bit 2 active, bit 4 overflow, bit 5 conversion error, bit 6 frame error |

## Verification
The hardest case to reach is a conversion error raised while adc_busy_i is still low. This happens when a second request arrives in the cycle right after an accepted one, before the converters have raised busy. Only the internal count of issued but unstored conversions can flag that request. The bench produces it by holding conv_req_i high for two consecutive cycles. The error is then checked against the busy-high variant and against a request that coincides with the busy falling edge, which must be accepted.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int unsigned STAT_W       = 16;
   localparam int unsigned ST_IDLE      = 0;
   localparam int unsigned ST_ACTIVE    = 2;
   localparam int unsigned ST_FIFO_OF   = 4;
   localparam int unsigned ST_CONV_ERR  = 5;
   localparam int unsigned ST_FRAME_ERR = 6;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_HALT = 2'd2
   } seq_state_t;

   typedef struct packed {
      logic frame;
      logic conv;
      logic fifo;
   } seq_err_t;

endpackage

// File: rtl/adc_seq_count.sv
// Issued / stored conversion counters for one run.
module adc_seq_count #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             issue_i,
   input  logic             store_i,
   input  logic [CNT_W-1:0] total_i,
   output logic             all_issued_o,
   output logic             last_store_o,
   output logic             pending_o
);
   localparam int unsigned EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] issued_q, stored_q, eff_total;

   // R5: a programmed total of zero behaves as one conversion
   assign eff_total = (total_i == '0) ? CNT_W'(1) : total_i;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         issued_q <= '0;
         stored_q <= '0;
      end else begin
         if (issue_i) issued_q <= issued_q + 1'b1;
         if (store_i) stored_q <= stored_q + 1'b1;
      end
   end

   assign all_issued_o = (issued_q == eff_total);
   assign last_store_o = (({1'b0, stored_q} + EXT_W'(1)) == {1'b0, eff_total});
   assign pending_o    = (issued_q != stored_q);

endmodule

// File: rtl/adc_seq_err.sv
// Sticky fault flags, cleared only while the unit is disabled.
module adc_seq_err
   import adc_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr_i,
   input  seq_err_t set_i,
   output seq_err_t flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) flag_o <= '0;
      else                 flag_o <= flag_o | set_i;
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned DATA_W    = 16,
   parameter bit          TRIG_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              frame_mode_i,
   input  logic              sw_start_i,
   input  logic              frame_trig_i,
   input  logic [CNT_W-1:0]  conv_total_i,
   input  logic              conv_req_i,
   input  logic              adc_busy_i,
   input  logic [DATA_W-1:0] adc_data_i,
   input  logic              fifo_full_i,
   output logic              conv_pulse_o,
   output logic              fifo_wr_o,
   output logic [DATA_W-1:0] fifo_data_o,
   output logic [STAT_W-1:0] status_o
);

   if (CNT_W < 1 || DATA_W < 1) begin : g_bad_cfg
      $error("adc_seq_ctrl: CNT_W and DATA_W must be at least 1");
   end

   seq_state_t state_q, state_d;
   seq_err_t   err_set, err_flag;
   logic       trig_evt, start_evt, run, busy_q, busy_fall;
   logic       occupied, any_set, issue, store, cnt_clr;
   logic       all_issued, last_store, pend;

   // frame trigger: edge detect or pre-formed pulse
   if (TRIG_EDGE) begin : g_trig_edge
      logic trig_q;
      always_ff @(posedge clk) begin
         if (!rst_n) trig_q <= 1'b0;
         else        trig_q <= frame_trig_i;
      end
      assign trig_evt = frame_trig_i & ~trig_q;
   end else begin : g_trig_pulse
      assign trig_evt = frame_trig_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= adc_busy_i;
   end
   assign busy_fall = busy_q & ~adc_busy_i;

   assign run       = (state_q == SEQ_RUN) & enable_i;
   assign start_evt = frame_mode_i ? trig_evt : sw_start_i;
   // converters are free when busy is low and every issued result is stored
   // (a result stored in this very cycle counts as free)
   assign occupied  = adc_busy_i | (pend & ~busy_fall);

   assign err_set.frame = run & frame_mode_i & trig_evt;
   assign err_set.conv  = run & conv_req_i & occupied;
   assign err_set.fifo  = run & busy_fall & pend & fifo_full_i;
   assign any_set       = |err_set;

   assign issue   = run & conv_req_i & ~occupied & ~all_issued & ~any_set;
   assign store   = run & busy_fall & pend & ~fifo_full_i & ~any_set;
   assign cnt_clr = ~enable_i | ((state_q == SEQ_IDLE) & start_evt);

   adc_seq_count #(.CNT_W(CNT_W)) u_count (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (cnt_clr),
      .issue_i      (issue),
      .store_i      (store),
      .total_i      (conv_total_i),
      .all_issued_o (all_issued),
      .last_store_o (last_store),
      .pending_o    (pend)
   );

   adc_seq_err u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (~enable_i),
      .set_i  (err_set),
      .flag_o (err_flag)
   );

   always_comb begin
      state_d = state_q;
      if (!enable_i) begin
         state_d = SEQ_IDLE;
      end else begin
         unique case (state_q)
            SEQ_IDLE: if (start_evt) state_d = SEQ_RUN;
            SEQ_RUN: begin
               if (any_set)                 state_d = SEQ_HALT;
               else if (store && last_store) state_d = SEQ_IDLE;
            end
            SEQ_HALT: state_d = SEQ_HALT;
            default:  state_d = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= SEQ_IDLE;
         conv_pulse_o <= 1'b0;
         fifo_wr_o    <= 1'b0;
         fifo_data_o  <= '0;
      end else begin
         state_q      <= state_d;
         conv_pulse_o <= issue;
         fifo_wr_o    <= store;
         if (store) fifo_data_o <= adc_data_i;
      end
   end

   always_comb begin
      status_o               = '0;
      status_o[ST_IDLE]      = (state_q == SEQ_IDLE);
      status_o[ST_ACTIVE]    = (state_q == SEQ_RUN);
      status_o[ST_FIFO_OF]   = err_flag.fifo;
      status_o[ST_CONV_ERR]  = err_flag.conv;
      status_o[ST_FRAME_ERR] = err_flag.frame;
   end

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
   import adc_seq_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              enable_i,
   input logic              conv_req_i,
   input logic              adc_busy_i,
   input logic              fifo_full_i,
   input logic              pend,
   input logic              conv_pulse_o,
   input logic              fifo_wr_o,
   input logic [STAT_W-1:0] status_o
);

   assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (status_o[6:4] == 3'b000 && status_o[0]));

   assert_errors_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && |status_o[6:4]) |=>
         ((status_o[6:4] & $past(status_o[6:4])) == $past(status_o[6:4])));

   assert_busy_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && status_o[2] && conv_req_i && adc_busy_i) |=> status_o[5]);

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && status_o[2] && $fell(adc_busy_i) && pend && fifo_full_i)
         |=> (status_o[4] && !fifo_wr_o));

   assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|status_o[6:4]) |-> (!conv_pulse_o && !fifo_wr_o && !status_o[2]));

   assert_idle_active_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({status_o[0], status_o[2]}));

   assert_pulse_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_pulse_o |-> status_o[2]);

   assert_write_not_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr_o |-> $past(!fifo_full_i));

endmodule

bind adc_seq_ctrl adc_seq_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .enable_i     (enable_i),
   .conv_req_i   (conv_req_i),
   .adc_busy_i   (adc_busy_i),
   .fifo_full_i  (fifo_full_i),
   .pend         (pend),
   .conv_pulse_o (conv_pulse_o),
   .fifo_wr_o    (fifo_wr_o),
   .status_o     (status_o)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
   localparam int CW = 4;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0, enable = 1'b0, fmode = 1'b0, swst = 1'b0, trig = 1'b0;
   logic [CW-1:0] total = '0;
   logic creq = 1'b0, busy = 1'b0, full = 1'b0;
   logic [DW-1:0] din = '0;
   logic pulse, wr;
   logic [DW-1:0] dout;
   logic [15:0] stat;
   int vectors = 0, misses = 0;

   always #10 clk = ~clk;

   adc_seq_ctrl #(.CNT_W(CW), .DATA_W(DW)) i_adc_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .enable_i(enable), .frame_mode_i(fmode),
      .sw_start_i(swst), .frame_trig_i(trig), .conv_total_i(total),
      .conv_req_i(creq), .adc_busy_i(busy), .adc_data_i(din),
      .fifo_full_i(full), .conv_pulse_o(pulse), .fifo_wr_o(wr),
      .fifo_data_o(dout), .status_o(stat));

   function automatic logic [15:0] st(input bit idle, input bit act,
                                      input bit ovf, input bit cer, input bit fer);
      logic [15:0] s = '0;
      s[0] = idle; s[2] = act; s[4] = ovf; s[5] = cer; s[6] = fer;
      return s;
   endfunction

   task automatic step();
      @(posedge clk); #5;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic start_run();
      if (fmode) trig = 1'b1; else swst = 1'b1;
      step();
      trig = 1'b0; swst = 1'b0;
   endtask

   // one full conversion; last selects the expected status after the write
   task automatic one_conv(input logic [DW-1:0] d, input bit last);
      creq = 1'b1; step(); creq = 1'b0;
      chk("R3 pulse", pulse, 1);
      busy = 1'b1; step();
      chk("R3 pulse width", pulse, 0);
      step();
      busy = 1'b0; din = d; step();
      chk("R4 write", wr, 1);
      chk("R4 data", dout, d);
      chk("R5 status after write", stat, last ? st(1,0,0,0,0) : st(0,1,0,0,0));
   endtask

   task automatic reenable();
      enable = 1'b0; step();
      chk("R11 disable clears", stat, st(1,0,0,0,0));
      enable = 1'b1; step();
   endtask

   initial begin
      #(20 * 150000);
      misses++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      step(); step();
      chk("R1 reset status", stat, st(1,0,0,0,0));
      chk("R12 reset reserved", stat & 16'hFF8A, 0);
      chk("R1 reset pulse", pulse, 0);
      chk("R1 reset write", wr, 0);
      rst_n = 1'b1; enable = 1'b1; step();

      // sweep both modes and totals 0..6
      for (int m = 0; m < 2; m++) begin
         for (int t = 0; t <= 6; t++) begin
            int e;
            e = (t == 0) ? 1 : t;
            fmode = m[0]; total = CW'(t); step();
            // the other mode's start input must be ignored
            if (m == 0) trig = 1'b1; else swst = 1'b1;
            step(); trig = 1'b0; swst = 1'b0;
            chk("R2 foreign start ignored", stat, st(1,0,0,0,0));
            for (int rep = 0; rep < 1 + m; rep++) begin
               start_run();
               chk(m ? "R6 frame starts run" : "R2 start sets active", stat, st(0,1,0,0,0));
               for (int i = 0; i < e; i++)
                  one_conv(DW'(m*64 + t*8 + i + rep), i == e-1);
               creq = 1'b1; step(); creq = 1'b0;
               chk("R3 no pulse past total", pulse, 0);
            end
         end
      end

      // frame error
      fmode = 1'b1; total = 4'd3; step();
      start_run();
      one_conv(8'h5A, 0);
      trig = 1'b1; step(); trig = 1'b0;
      chk("R7 frame error", stat, st(0,0,0,0,1));
      creq = 1'b1; step(); creq = 1'b0;
      chk("R10 halted no pulse", pulse, 0);
      trig = 1'b1; step(); trig = 1'b0; step();
      chk("R10 trigger ignored", stat, st(0,0,0,0,1));
      chk("R11 sticky", stat[6], 1);
      reenable();

      // conversion error: second request before busy rises
      fmode = 1'b0; total = 4'd3; step();
      start_run();
      creq = 1'b1; step();
      chk("R3 first accepted", pulse, 1);
      step(); creq = 1'b0;
      chk("R8 pending request error", stat, st(0,0,0,1,0));
      chk("R10 no pulse on error", pulse, 0);
      swst = 1'b1; step(); swst = 1'b0;
      chk("R10 start ignored", stat, st(0,0,0,1,0));
      reenable();

      // conversion error: request while busy high
      start_run();
      creq = 1'b1; step(); creq = 1'b0;
      busy = 1'b1; step();
      creq = 1'b1; step(); creq = 1'b0;
      chk("R8 busy request error", stat, st(0,0,0,1,0));
      busy = 1'b0; step();
      chk("R10 no write after halt", wr, 0);
      reenable();

      // request coincident with busy falling edge is accepted
      start_run();
      creq = 1'b1; step(); creq = 1'b0;
      busy = 1'b1; step();
      busy = 1'b0; din = 8'h33; creq = 1'b1; step(); creq = 1'b0;
      chk("R8 request at fall accepted", pulse, 1);
      chk("R4 write at fall", wr, 1);
      chk("R8 no error", stat, st(0,1,0,0,0));
      reenable();

      // FIFO overflow
      total = 4'd2; step();
      start_run();
      creq = 1'b1; step(); creq = 1'b0;
      busy = 1'b1; step();
      full = 1'b1; busy = 1'b0; step();
      chk("R9 overflow flag", stat, st(0,0,1,0,0));
      chk("R9 no write", wr, 0);
      full = 1'b0; step();
      chk("R11 overflow sticky", stat, st(0,0,1,0,0));
      reenable();
      chk("R11 fresh run allowed", stat, st(1,0,0,0,0));
      start_run();
      chk("R11 run after reenable", stat, st(0,1,0,0,0));

      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule